// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output-compare channel. Every cycle it compares a 16-bit compare register against the count of one of two external free-running timers. When the count reaches the compare value, the channel acts according to a 4-bit action mode. It can drive its output latch high, drive it low, or toggle it. In every active mode it also raises a sticky interrupt flag. In trigger mode it sends a one-cycle clear pulse back to the timer that is selected, so the compare register then sets that timer's period. One variant of the channel, chosen by a parameter, also issues a converter-start pulse on that trigger.

Software loads the compare value through one write port. It loads a control word through a second write port. The control word holds the action mode in bits [3:0], the timer select in bit 4 (0 selects timer 0, 1 selects timer 1) and the output enable in bit 5. When the output enable is clear, the pin is reported as high-impedance.

The design uses two state machines. The match tracker has three states. It sits in `CS_OFF` while the mode is inactive. It moves to `CS_WAIT` when the mode is active and the count differs from the compare value. It moves to `CS_HIT` when the two are equal. The match pulse is produced only on the transition from `CS_WAIT` to `CS_HIT`. From `CS_HIT` it returns to `CS_WAIT` when the values differ again. If the mode becomes inactive, the tracker goes back to `CS_OFF` from any state. The output latch has two states, `LAT_LO` and `LAT_HI`. It moves between them on set, clear or toggle matches. Writing a control word of zero forces it to `LAT_LO`.

Top module: `ocmp_channel`

## Requirements
- R1: The compare value is checked against timer 0 when the timer select bit (control bit 4) is 0, and against timer 1 when it is 1. Equality on the timer that is not selected causes no action and no flag.
- R2: On a match, mode 4'b1000 drives the latch high, mode 4'b1001 drives it low, and mode 4'b0010 inverts it. The latch changes on the clock edge of the match cycle.
- R3: A match in any active mode sets `irq_flag` on the match edge. The flag stays set until `flag_clr` is high for a cycle. If a match and `flag_clr` happen in the same cycle, the flag stays set.
- R4: Mode 4'b1010 sets only the flag on a match and leaves the latch unchanged.
- R5: Mode 4'b1011 leaves the latch unchanged on a match. In the cycle after the match it pulses `tmr_clr` for exactly one cycle: bit 0 clears timer 0 and bit 1 clears timer 1, and only the selected timer's bit is pulsed.
- R6: With `HAS_ADC_START`=1, a trigger-mode match pulses `adc_start` in the same cycle as `tmr_clr`, but only if `adc_enabled` was high in the match cycle.
- R7: Writing an all-zero control word forces the latch low on that clock edge. A nonzero control write does not change the latch by itself.
- R8: `pin_oe` follows control bit 5. When bit 5 is 0, `pin_out` reads 0 (high-impedance). When it is 1, `pin_out` shows the latch.
- R9: Equality held over several cycles gives one action and one flag set. A further action needs the values to differ and then match again.
- R10: The modes not listed in R2, R4 and R5 (for example 4'b0101) take no action and set no flag on equality.
- R11: After reset, the compare value, the control word, the latch, the flag and all pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_cmp | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | New compare value |
| wr_ctl | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 6 | Control word: [3:0] mode, [4] timer select, [5] output enable |
| tmr0_cnt | input | 16 | Count of timer 0 |
| tmr1_cnt | input | 16 | Count of timer 1 |
| adc_enabled | input | 1 | Converter is ready to accept a start pulse |
| flag_clr | input | 1 | Clears the interrupt flag |
| tmr_clr | output | 2 | One-cycle clear pulse, one bit per timer |
| adc_start | output | 1 | One-cycle converter start pulse |
| pin_out | output | 1 | Compare pin value (0 when not driven) |
| pin_oe | output | 1 | Pin output enable |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench keeps the count equal to the compare value for several cycles in a row. A design that acts on level rather than on the edge would toggle the latch again each cycle and would set the flag again right after it was cleared. The bench puts a match and a flag clear in the same cycle, where a design giving the clear priority would lose the interrupt. It puts equality only on the timer that is not selected, which would expose a swapped or missing select. It writes a zero control word after the latch is high and then re-enables the pin, so a design that does not force the latch low would show a stale high. Trigger mode is run with the converter both enabled and disabled, and on each timer, so a wrong clear bit or an ungated start pulse is seen on the ports.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] MD_TOGGLE = 4'b0010;
    localparam logic [MODE_W-1:0] MD_SET    = 4'b1000;
    localparam logic [MODE_W-1:0] MD_CLR    = 4'b1001;
    localparam logic [MODE_W-1:0] MD_SWINT  = 4'b1010;
    localparam logic [MODE_W-1:0] MD_TRIG   = 4'b1011;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_WAIT = 2'd1,
        CS_HIT  = 2'd2
    } cmp_state_e;

    typedef enum logic {
        LAT_LO = 1'b0,
        LAT_HI = 1'b1
    } lat_state_e;

    function automatic logic mode_active(input logic [MODE_W-1:0] m);
        return (m == MD_TOGGLE) || (m == MD_SET) || (m == MD_CLR) ||
               (m == MD_SWINT)  || (m == MD_TRIG);
    endfunction

endpackage

// File: rtl/ocmp_match_fsm.sv
module ocmp_match_fsm
    import ocmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt_sel,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             match
);

    cmp_state_e state_q, state_d;
    logic       equal;

    assign equal = (cnt_sel == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = CS_OFF;
        end else begin
            unique case (state_q)
                CS_OFF:  state_d = equal ? CS_HIT : CS_WAIT;
                CS_WAIT: state_d = equal ? CS_HIT : CS_WAIT;
                CS_HIT:  state_d = equal ? CS_HIT : CS_WAIT;
                default: state_d = CS_OFF;
            endcase
        end
    end

    always_comb begin
        match = active && equal && (state_q == CS_WAIT);
    end

endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
    import ocmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic [MODE_W-1:0] mode,
    input  logic              tsel,
    input  logic              force_low,
    input  logic              flag_clr,
    input  logic              adc_gate,
    output logic              latch,
    output logic              flag,
    output logic [1:0]        tmr_clr,
    output logic              adc_start
);

    lat_state_e lat_q, lat_d;
    logic       flag_q, flag_d;
    logic [1:0] clr_q, clr_d;
    logic       adc_q, adc_d;
    logic       trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= LAT_LO;
            flag_q <= 1'b0;
            clr_q  <= '0;
            adc_q  <= 1'b0;
        end else begin
            lat_q  <= lat_d;
            flag_q <= flag_d;
            clr_q  <= clr_d;
            adc_q  <= adc_d;
        end
    end

    always_comb begin
        lat_d = lat_q;
        if (force_low) begin
            lat_d = LAT_LO;
        end else if (match) begin
            unique case (mode)
                MD_SET:    lat_d = LAT_HI;
                MD_CLR:    lat_d = LAT_LO;
                MD_TOGGLE: lat_d = (lat_q == LAT_HI) ? LAT_LO : LAT_HI;
                default:   lat_d = lat_q;
            endcase
        end
    end

    always_comb begin
        trig   = match && (mode == MD_TRIG);
        flag_d = match ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
        clr_d  = trig ? (tsel ? 2'b10 : 2'b01) : 2'b00;
        adc_d  = trig && adc_gate;
    end

    assign latch     = (lat_q == LAT_HI);
    assign flag      = flag_q;
    assign tmr_clr   = clr_q;
    assign adc_start = adc_q;

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter bit HAS_ADC_START = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             wr_ctl,
    input  logic [5:0]       ctl_wdata,
    input  logic [CNT_W-1:0] tmr0_cnt,
    input  logic [CNT_W-1:0] tmr1_cnt,
    input  logic             adc_enabled,
    input  logic             flag_clr,
    output logic [1:0]       tmr_clr,
    output logic             adc_start,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             irq_flag
);

    localparam int TSEL_BIT = MODE_W;
    localparam int OE_BIT   = MODE_W + 1;

    logic [CNT_W-1:0]  cmp_q;
    logic [MODE_W-1:0] mode_q;
    logic              tsel_q;
    logic              oe_q;
    logic [CNT_W-1:0]  cnt_sel;
    logic              match;
    logic              force_low;
    logic              adc_gate;
    logic              cmp_latch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= '0;
            tsel_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (wr_cmp) cmp_q <= cmp_wdata;
            if (wr_ctl) begin
                mode_q <= ctl_wdata[MODE_W-1:0];
                tsel_q <= ctl_wdata[TSEL_BIT];
                oe_q   <= ctl_wdata[OE_BIT];
            end
        end
    end

    assign cnt_sel   = tsel_q ? tmr1_cnt : tmr0_cnt;
    assign force_low = wr_ctl && (ctl_wdata == '0);

    generate
        if (HAS_ADC_START) begin : g_adc
            assign adc_gate = adc_enabled;
        end else begin : g_no_adc
            assign adc_gate = 1'b0 & adc_enabled;
        end
    endgenerate

    ocmp_match_fsm #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (mode_active(mode_q)),
        .cnt_sel (cnt_sel),
        .cmp_val (cmp_q),
        .match   (match)
    );

    ocmp_action u_action (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .mode      (mode_q),
        .tsel      (tsel_q),
        .force_low (force_low),
        .flag_clr  (flag_clr),
        .adc_gate  (adc_gate),
        .latch     (cmp_latch),
        .flag      (irq_flag),
        .tmr_clr   (tmr_clr),
        .adc_start (adc_start)
    );

    assign pin_oe  = oe_q;
    assign pin_out = oe_q & cmp_latch;

endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk
    import ocmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              match,
    input logic [MODE_W-1:0] mode_q,
    input logic              tsel_q,
    input logic              wr_ctl,
    input logic [5:0]        ctl_wdata,
    input logic              latch,
    input logic              irq_flag,
    input logic [1:0]        tmr_clr,
    input logic              adc_start,
    input logic              pin_out,
    input logic              pin_oe
);

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> irq_flag); // R3

    AST_SWINT_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q == MD_SWINT && !wr_ctl) |=> $stable(latch)); // R4

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_clr)); // R5

    AST_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode_q == MD_TRIG && !tsel_q) |=> (tmr_clr == 2'b01)); // R5

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_clr != 2'b00) |=> (tmr_clr == 2'b00)); // R5

    AST_ADC_WITH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (tmr_clr != 2'b00)); // R6

    AST_ZERO_WRITE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_wdata == 6'd0) |=> !latch); // R7

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out); // R8

    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match); // R9

endmodule

bind ocmp_channel ocmp_channel_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .mode_q    (mode_q),
    .tsel_q    (tsel_q),
    .wr_ctl    (wr_ctl),
    .ctl_wdata (ctl_wdata),
    .latch     (cmp_latch),
    .irq_flag  (irq_flag),
    .tmr_clr   (tmr_clr),
    .adc_start (adc_start),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/ocmp_channel_tb.sv
`timescale 1ns/1ps
module ocmp_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_cmp = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        wr_ctl = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic [15:0] tmr0_cnt = 16'h0000;
    logic [15:0] tmr1_cnt = 16'h0000;
    logic        adc_enabled = 1'b0;
    logic        flag_clr = 1'b0;
    logic [1:0]  tmr_clr;
    logic        adc_start;
    logic        pin_out;
    logic        pin_oe;
    logic        irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ocmp_channel #(.CNT_W(16), .HAS_ADC_START(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_cmp(wr_cmp), .cmp_wdata(cmp_wdata),
        .wr_ctl(wr_ctl), .ctl_wdata(ctl_wdata), .tmr0_cnt(tmr0_cnt),
        .tmr1_cnt(tmr1_cnt), .adc_enabled(adc_enabled), .flag_clr(flag_clr),
        .tmr_clr(tmr_clr), .adc_start(adc_start), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq_flag(irq_flag)
    );

    typedef struct packed {
        logic [5:0]  ctl;
        logic [15:0] cmp;
        logic [15:0] ta;
        logic [15:0] tb;
        logic        adc;
        logic        e_pin;
        logic        e_oe;
        logic        e_flag;
        logic [1:0]  e_clr;
        logic        e_adc;
    } vec_t;

    // ctl = {oe, tsel, mode}; latch carries over from one row to the next
    localparam vec_t VEC [10] = '{
        '{6'h28, 16'h1234, 16'h1234, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0}, // R2 set
        '{6'h39, 16'h00FF, 16'h00FF, 16'h00FF, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0}, // R2 clear
        '{6'h38, 16'hABCD, 16'hABCD, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R1 unselected
        '{6'h22, 16'h8000, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0}, // R2 toggle
        '{6'h2A, 16'h0F0F, 16'h0F0F, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0}, // R4
        '{6'h3B, 16'h0100, 16'h0000, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1}, // R5 R6
        '{6'h2B, 16'h0200, 16'h0200, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0}, // R5 R6
        '{6'h22, 16'h4000, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0}, // R2 toggle
        '{6'h25, 16'h0300, 16'h0300, 16'h0300, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R10
        '{6'h08, 16'h0777, 16'h0777, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0}  // R8
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 pin_out", {15'd0, pin_out}, 16'd0);
        check("R11 pin_oe", {15'd0, pin_oe}, 16'd0);
        check("R11 irq_flag", {15'd0, irq_flag}, 16'd0);
        check("R11 tmr_clr", {14'd0, tmr_clr}, 16'd0);
        check("R11 adc_start", {15'd0, adc_start}, 16'd0);
        rst_n = 1'b1;
        cyc();

        for (int i = 0; i < 10; i++) begin
            wr_ctl = 1'b1; ctl_wdata = VEC[i].ctl;
            wr_cmp = 1'b1; cmp_wdata = VEC[i].cmp;
            flag_clr = 1'b1;
            tmr0_cnt = ~VEC[i].cmp; tmr1_cnt = ~VEC[i].cmp;
            adc_enabled = VEC[i].adc;
            cyc();
            wr_ctl = 1'b0; wr_cmp = 1'b0; flag_clr = 1'b0;
            cyc();
            tmr0_cnt = VEC[i].ta; tmr1_cnt = VEC[i].tb;
            cyc();
            check($sformatf("R2 vec%0d pin_out", i), {15'd0, pin_out}, {15'd0, VEC[i].e_pin});
            check($sformatf("R8 vec%0d pin_oe", i), {15'd0, pin_oe}, {15'd0, VEC[i].e_oe});
            check($sformatf("R3 vec%0d irq_flag", i), {15'd0, irq_flag}, {15'd0, VEC[i].e_flag});
            check($sformatf("R5 vec%0d tmr_clr", i), {14'd0, tmr_clr}, {14'd0, VEC[i].e_clr});
            check($sformatf("R6 vec%0d adc_start", i), {15'd0, adc_start}, {15'd0, VEC[i].e_adc});
        end
        cyc();
        check("R5 tmr_clr pulse ends", {14'd0, tmr_clr}, 16'd0);

        // R7: latch is high here (last row); enable pin with inactive mode
        wr_ctl = 1'b1; ctl_wdata = 6'h20; tmr0_cnt = 16'hAAAA;
        cyc();
        check("R7 nonzero write keeps latch", {15'd0, pin_out}, 16'd1);
        ctl_wdata = 6'h00;
        cyc();
        ctl_wdata = 6'h20;
        cyc();
        wr_ctl = 1'b0;
        check("R7 zero write forced latch low", {15'd0, pin_out}, 16'd0);

        // R9: held equality toggles only once
        wr_ctl = 1'b1; ctl_wdata = 6'h22; wr_cmp = 1'b1; cmp_wdata = 16'h0055;
        flag_clr = 1'b1;
        cyc();
        wr_ctl = 1'b0; wr_cmp = 1'b0; flag_clr = 1'b0;
        cyc();
        tmr0_cnt = 16'h0055;
        for (int k = 0; k < 4; k++) begin
            cyc();
            check($sformatf("R9 held cycle %0d pin_out", k), {15'd0, pin_out}, 16'd1);
        end
        flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
        cyc();
        check("R9 no re-set while held", {15'd0, irq_flag}, 16'd0);
        tmr0_cnt = 16'h0054;
        cyc();
        tmr0_cnt = 16'h0055;
        cyc();
        check("R9 new edge toggles", {15'd0, pin_out}, 16'd0);
        check("R3 flag set on new edge", {15'd0, irq_flag}, 16'd1);

        // R3: match and clear in the same cycle -> flag stays set
        tmr0_cnt = 16'h0000; flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
        check("R3 clear alone", {15'd0, irq_flag}, 16'd0);
        tmr0_cnt = 16'h0055; flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
        check("R3 set wins over clear", {15'd0, irq_flag}, 16'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule